// File: doc/BRIEF.md
# Synchronous Edge-Capture Time Digitizer

This block converts an asynchronous hit, typically the output of a comparator watching a ramp, into a timestamp that is fully synchronous to the system clock. The hit is never used as a clock. A bank of phase-shifted sampling flip-flops takes it only on their data inputs and presents one word of tap samples per system clock, with tap 0 the earliest phase and the top tap the latest. Everything downstream of that word runs on the single system clock. A transition encoder finds where in the word the hit changed level and which way it went. A plain binary coarse counter supplies the clock count of the sampling cycle. A final register stage hands the combined result to readout logic.

One sampling array and one encoder serve both rising and falling transitions. The array is never cleared between hits, so a result can be produced on every clock. The tap word is an input, because the delay line and phased clocks that fill it lie outside this block. The result leaves as a valid-only stream with no ready input: a hit cannot be held off, so the consumer has to accept a result in the cycle its valid is high. Between results, the data fields keep the last result.

Top module: `edge_stamp_tdc`

## Requirements
- R1: In reset, and on the first cycle after release, the valid output is low and the fine, edge and coarse outputs are all zero. Reset clears the coarse counter and the stored latest tap of the previous word to 0.
- R2: Compare each tap i>0 with tap i-1, and compare tap 0 with the latest tap of the word sampled one clock earlier. The fine output is the lowest index i where these differ.
- R3: The edge output is 1 (rising) when the tap at the reported index is 1, and 0 (falling) when it is 0.
- R4: When a word holds several transitions, only the lowest-index one is reported.
- R5: A word with no transition gives valid low, and the fine, edge and coarse outputs keep their previous values.
- R6: The coarse counter starts at 0 after reset and adds one on every clock, wrapping at 2^COARSE_W. The coarse output is the counter value in the cycle before the sampling edge of the word, which equals the number of clocks since reset release.
- R7: A word sampled at clock edge k produces its result on the outputs after edge k+2.
- R8: Words with transitions on consecutive clocks each produce a result on consecutive cycles, with no dead time.
- R9: A transition lying between the last tap of one word and tap 0 of the next is reported in the later word with fine value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_i | input | TAPS | Phased samples of the hit for the current clock, bit 0 earliest |
| stamp_valid_o | output | 1 | High for one cycle per detected transition |
| stamp_edge_o | output | 1 | 1 rising, 0 falling |
| stamp_fine_o | output | $clog2(TAPS+1) | Tap index of the transition |
| stamp_coarse_o | output | COARSE_W | Clock count of the sampling cycle |

## Verification
The bench feeds back-to-back tap words whose transitions sit at the first and last taps, cross the word boundary, or occur twice in one word. A design that ignored the carried-over latest tap would miss boundary hits or report them at the wrong index. One that searched from the top of the word would report the later of two transitions. A design with dead time would drop the second of two adjacent hits. The bench also places hits on either side of the coarse counter wrap, where a misaligned count pipeline shows up as an off-by-one coarse value. It asserts reset in the middle of a run to show that the counter and the carried-over tap both restart from zero.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} edge_dir_e;

  function automatic int fine_bits(input int taps);
    return $clog2(taps + 1);
  endfunction
endpackage

// File: rtl/tap_capture.sv
module tap_capture #(
  parameter int TAPS     = 16,
  parameter int COARSE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TAPS-1:0]     tap_i,
  input  logic [COARSE_W-1:0] cnt_i,
  output logic [TAPS-1:0]     word_o,
  output logic                carry_o,
  output logic [COARSE_W-1:0] word_cnt_o
);
  // word register: the hit only ever reaches D pins; never cleared between hits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o     <= '0;
      carry_o    <= 1'b0;
      word_cnt_o <= '0;
    end else begin
      word_o     <= tap_i;
      carry_o    <= word_o[TAPS-1];
      word_cnt_o <= cnt_i;
    end
  end
endmodule

// File: rtl/coarse_counter.sv
module coarse_counter #(
  parameter int COARSE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [COARSE_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/edge_encoder.sv
module edge_encoder #(
  parameter int TAPS     = 16,
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TAPS-1:0]     word_i,
  input  logic                carry_i,
  input  logic [COARSE_W-1:0] word_cnt_i,
  output logic                enc_valid_o,
  output logic                enc_edge_o,
  output logic [FINE_W-1:0]   enc_fine_o,
  output logic [COARSE_W-1:0] enc_cnt_o
);
  logic [TAPS-1:0]   diff;
  logic [FINE_W-1:0] first_idx;
  logic              first_lvl;

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_diff
      if (g == 0) begin : g_head
        assign diff[g] = word_i[g] ^ carry_i;
      end else begin : g_body
        assign diff[g] = word_i[g] ^ word_i[g-1];
      end
    end
  endgenerate

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    first_idx = '0;
    first_lvl = 1'b0;
    for (int i = TAPS - 1; i >= 0; i--) begin
      if (diff[i]) begin
        first_idx = FINE_W'(i);
        first_lvl = word_i[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_valid_o <= 1'b0;
      enc_edge_o  <= stamp_pkg::EDGE_FALL;
      enc_fine_o  <= '0;
      enc_cnt_o   <= '0;
    end else begin
      enc_valid_o <= |diff;
      if (|diff) begin
        enc_edge_o <= first_lvl;
        enc_fine_o <= first_idx;
        enc_cnt_o  <= word_cnt_i;
      end
    end
  end
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int COARSE_W = 12,
  parameter int FINE_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enc_valid_i,
  input  logic                enc_edge_i,
  input  logic [FINE_W-1:0]   enc_fine_i,
  input  logic [COARSE_W-1:0] enc_cnt_i,
  output logic                valid_o,
  output logic                edge_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic [COARSE_W-1:0] coarse_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      edge_o   <= 1'b0;
      fine_o   <= '0;
      coarse_o <= '0;
    end else begin
      valid_o <= enc_valid_i;
      if (enc_valid_i) begin
        edge_o   <= enc_edge_i;
        fine_o   <= enc_fine_i;
        coarse_o <= enc_cnt_i;
      end
    end
  end
endmodule

// File: rtl/edge_stamp_tdc.sv
module edge_stamp_tdc #(
  parameter int TAPS     = 16,
  parameter int COARSE_W = 12,
  localparam int FINE_W  = stamp_pkg::fine_bits(TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TAPS-1:0]     tap_i,
  output logic                stamp_valid_o,
  output logic                stamp_edge_o,
  output logic [FINE_W-1:0]   stamp_fine_o,
  output logic [COARSE_W-1:0] stamp_coarse_o
);
  logic [COARSE_W-1:0] cnt_q;
  logic [TAPS-1:0]     word_q;
  logic                carry_q;
  logic [COARSE_W-1:0] word_cnt_q;
  logic                enc_valid;
  logic                enc_edge;
  logic [FINE_W-1:0]   enc_fine;
  logic [COARSE_W-1:0] enc_cnt;

  coarse_counter #(.COARSE_W(COARSE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt_q)
  );

  tap_capture #(.TAPS(TAPS), .COARSE_W(COARSE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .tap_i(tap_i), .cnt_i(cnt_q),
    .word_o(word_q), .carry_o(carry_q), .word_cnt_o(word_cnt_q)
  );

  edge_encoder #(.TAPS(TAPS), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .word_i(word_q), .carry_i(carry_q),
    .word_cnt_i(word_cnt_q), .enc_valid_o(enc_valid), .enc_edge_o(enc_edge),
    .enc_fine_o(enc_fine), .enc_cnt_o(enc_cnt)
  );

  result_stage #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .enc_valid_i(enc_valid), .enc_edge_i(enc_edge),
    .enc_fine_i(enc_fine), .enc_cnt_i(enc_cnt), .valid_o(stamp_valid_o),
    .edge_o(stamp_edge_o), .fine_o(stamp_fine_o), .coarse_o(stamp_coarse_o)
  );
endmodule

// File: rtl/edge_stamp_tdc_chk.sv
module edge_stamp_tdc_chk #(
  parameter int TAPS     = 16,
  parameter int COARSE_W = 12,
  localparam int FINE_W  = stamp_pkg::fine_bits(TAPS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stamp_valid_o,
  input logic                stamp_edge_o,
  input logic [FINE_W-1:0]   stamp_fine_o,
  input logic [COARSE_W-1:0] stamp_coarse_o,
  input logic [COARSE_W-1:0] cnt_q,
  input logic                enc_valid
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!stamp_valid_o && stamp_fine_o == '0 &&
                      stamp_coarse_o == '0 && cnt_q == '0));

  assert_fine_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid_o |-> (stamp_fine_o < FINE_W'(TAPS)));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_valid_o |-> ($stable(stamp_fine_o) && $stable(stamp_edge_o) &&
                        $stable(stamp_coarse_o)));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt_q == COARSE_W'($past(cnt_q) + 1'b1)));

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> stamp_valid_o);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid |=> !stamp_valid_o);
endmodule

bind edge_stamp_tdc edge_stamp_tdc_chk #(.TAPS(TAPS), .COARSE_W(COARSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stamp_valid_o(stamp_valid_o),
  .stamp_edge_o(stamp_edge_o), .stamp_fine_o(stamp_fine_o),
  .stamp_coarse_o(stamp_coarse_o), .cnt_q(cnt_q), .enc_valid(enc_valid)
);

// File: tb/edge_stamp_tdc_tb.sv
`timescale 1ns/1ps
module edge_stamp_tdc_tb;
  localparam int TAPS = 16;
  localparam int CW   = 12;
  localparam int FW   = 5;
  localparam int NV   = 12;

  logic            clk   = 1'b0;
  logic            rst_n = 1'b0;
  logic [TAPS-1:0] tap   = '0;
  logic            sv, se;
  logic [FW-1:0]   sf;
  logic [CW-1:0]   sc;

  int errors = 0;
  int checks = 0;
  int edge_n = 0;
  bit done   = 1'b0;

  // {taps[22:7], valid[6], edge[5], fine[4:0]}
  localparam logic [22:0] VEC [NV] = '{
    {16'h0000, 1'b0, 1'b0, 5'd0},
    {16'hFFF0, 1'b1, 1'b1, 5'd4},
    {16'hFFFF, 1'b0, 1'b0, 5'd0},
    {16'h0000, 1'b1, 1'b0, 5'd0},
    {16'h8000, 1'b1, 1'b1, 5'd15},
    {16'h00FF, 1'b1, 1'b0, 5'd8},
    {16'h0FF0, 1'b1, 1'b1, 5'd4},
    {16'h0001, 1'b1, 1'b1, 5'd0},
    {16'hFFFE, 1'b1, 1'b1, 5'd1},
    {16'hFFFF, 1'b0, 1'b0, 5'd0},
    {16'h7FFF, 1'b1, 1'b0, 5'd15},
    {16'h0000, 1'b0, 1'b0, 5'd0}
  };

  edge_stamp_tdc #(.TAPS(TAPS), .COARSE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tap_i(tap), .stamp_valid_o(sv),
    .stamp_edge_o(se), .stamp_fine_o(sf), .stamp_coarse_o(sc)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input int v, input int e, input int f, input int c);
    chk(req, "valid", int'(sv), v);
    chk(req, "edge", int'(se), e);
    chk(req, "fine", int'(sf), f);
    chk(req, "coarse", int'(sc), c);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_c [NV];
    int hold_e, hold_f, hold_c;
    bit prev_v;
    int c_wrap_a, c_wrap_b;
    hold_e = 0; hold_f = 0; hold_c = 0; prev_v = 1'b0;

    // R1: state held in reset
    repeat (3) @(negedge clk);
    chk_out("R1", 0, 0, 0, 0);
    rst_n = 1'b1;

    // table walk: word j sampled at the next edge, checked three negedges later (R7)
    for (int j = 0; j < NV + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        int k;
        logic [22:0] e;
        string tag;
        k = j - 3;
        e = VEC[k];
        if (e[6]) begin
          hold_e = int'(e[5]);
          hold_f = int'(e[4:0]);
          hold_c = exp_c[k];
          tag = prev_v ? "R8" : "R7";
        end else begin
          tag = "R5";
        end
        chk(tag, "valid", int'(sv), int'(e[6]));
        if (!e[6])                    tag = "R5";
        else if (k == 6)              tag = "R4";
        else if (e[4:0] == 5'd0)      tag = "R9";
        else                          tag = "R2";
        chk(tag, "fine", int'(sf), hold_f);
        chk(e[6] ? "R3" : "R5", "edge", int'(se), hold_e);
        chk(e[6] ? "R6" : "R5", "coarse", int'(sc), hold_c);
        prev_v = e[6];
      end
      if (j < NV) begin
        tap = VEC[j][22:7];
        exp_c[j] = edge_n % 4096;
      end else begin
        tap = '0;
      end
    end

    // R6: hits on both sides of the coarse wrap
    while (edge_n != 4095) @(negedge clk);
    tap = 16'h0010; c_wrap_a = edge_n % 4096;
    @(negedge clk);
    tap = 16'h0100; c_wrap_b = edge_n % 4096;
    @(negedge clk);
    tap = '0;
    @(negedge clk);
    chk_out("R6", 1, 1, 4, c_wrap_a);
    chk("R6", "coarse before wrap", c_wrap_a, 4095);
    @(negedge clk);
    chk_out("R6", 1, 1, 8, c_wrap_b);
    @(negedge clk);
    chk_out("R5", 0, 1, 8, c_wrap_b);

    // R1: reset mid-run clears outputs, counter and carried tap
    rst_n = 1'b0;
    @(negedge clk);
    chk_out("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    tap = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk_out("R1", 1, 1, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule